// File: doc/BRIEF.md
# Multi-Edge Up/Down Routing Switch

This block is one switching element of a multistage network in which every switch links onward to its next stage through several parallel edges in each of two directions. The element has `2*DILATION` input ports. It has `DILATION` output edges on the up side and `DILATION` output edges on the down side. Every input carries a valid flag, a destination address and a payload. A single address bit, fixed by the element's stage index, chooses the direction. Within a direction, all edges are interchangeable, so the element hands them out to the messages that ask for that direction.

Every cycle the element takes a fresh set of messages. A message that finds no free edge on its side is discarded, and a per-port blocked flag reports the discard. The element holds no queue and makes no second attempt. The allocation logic is purely combinational. Its results reach the outputs through one bank of registers.

Top module: `dsplit_node`

## Requirements
- R1: For the stage index `STAGE`, the direction comes from address bit `ADDR_W-1-STAGE`: value 0 sends the message up and value 1 sends it down. No other address bit affects the decision.
- R2: Within one direction, requesting inputs receive edges in ascending port order. The lowest-numbered requester gets edge 0, the next one gets edge 1, and so on.
- R3: Each direction grants at most `DILATION` messages per cycle. Any further requester in that direction is dropped, and its bit in `blocked` is raised.
- R4: An input with its valid flag low takes no edge and never raises its blocked bit.
- R5: An output edge that carries no message drives its valid flag low.
- R6: The results for the inputs presented before a rising clock edge appear on the outputs right after that edge, one cycle of latency. The address and payload arrive unchanged.
- R7: While reset is active, and just after it is released, every output valid flag and every blocked bit is low.
- R8: The occupied edges on each side always form a run that starts at edge 0, with no gaps.
- R9: The two directions are allocated independently: if one side is saturated, the grants on the other side do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 2*DILATION | Valid flag per input port |
| in_addr | input | 2*DILATION x ADDR_W | Destination address per input port |
| in_data | input | 2*DILATION x DATA_W | Payload per input port |
| up_valid | output | DILATION | Valid flag per up-side edge |
| up_addr | output | DILATION x ADDR_W | Address on each up-side edge |
| up_data | output | DILATION x DATA_W | Payload on each up-side edge |
| dn_valid | output | DILATION | Valid flag per down-side edge |
| dn_addr | output | DILATION x ADDR_W | Address on each down-side edge |
| dn_data | output | DILATION x DATA_W | Payload on each down-side edge |
| blocked | output | 2*DILATION | Per input port: message dropped for lack of an edge |

## Verification
The bench builds the element with `DILATION=2`, `ADDR_W=3`, `DATA_W=8` and `STAGE=1`, which makes address bit 1 the steering bit. This setup has four inputs competing for two edges per side, so a single cycle can saturate one side while the other side stays partly free. Because the steering bit sits in the middle of the address, toggling the bits on either side of it shows whether the wrong bit is being decoded. A long run of random back-to-back cycles checks the one-cycle latency and confirms that no state is carried from one cycle to the next.

// File: rtl/dsplit_pkg.sv
package dsplit_pkg;

   typedef enum logic {
      SIDE_UP = 1'b0,
      SIDE_DN = 1'b1
   } side_e;

   localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/dsplit_steer.sv
module dsplit_steer
   import dsplit_pkg::*;
#(
   parameter int unsigned PORTS  = 4,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned STAGE  = 0
) (
   input  logic [PORTS-1:0]             valid,
   input  logic [PORTS-1:0][ADDR_W-1:0] addr,
   output logic [NUM_SIDES-1:0][PORTS-1:0] req
);

   localparam int unsigned SEL_BIT = ADDR_W - 1 - STAGE;

   if (STAGE >= ADDR_W) begin : g_bad_stage
      $error("dsplit_steer: STAGE must be below ADDR_W");
   end

   for (genvar i = 0; i < PORTS; i++) begin : g_port
      side_e side;
      assign side = side_e'(addr[i][SEL_BIT]);
      assign req[SIDE_UP][i] = valid[i] && (side == SIDE_UP);
      assign req[SIDE_DN][i] = valid[i] && (side == SIDE_DN);
   end

endmodule

// File: rtl/dsplit_alloc.sv
module dsplit_alloc #(
   parameter int unsigned PORTS  = 4,
   parameter int unsigned EDGES  = 2,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic [PORTS-1:0]             req,
   input  logic [PORTS-1:0][ADDR_W-1:0] addr,
   input  logic [PORTS-1:0][DATA_W-1:0] data,
   output logic [EDGES-1:0]             edge_v,
   output logic [EDGES-1:0][ADDR_W-1:0] edge_a,
   output logic [EDGES-1:0][DATA_W-1:0] edge_d,
   output logic [PORTS-1:0]             reject
);

   localparam int unsigned RANK_W = $clog2(PORTS + 1);

   if (EDGES > PORTS) begin : g_bad_edges
      $error("dsplit_alloc: EDGES must not exceed PORTS");
   end

   always_comb begin
      logic [RANK_W-1:0] rank;
      rank   = '0;
      edge_v = '0;
      edge_a = '0;
      edge_d = '0;
      reject = '0;
      for (int i = 0; i < PORTS; i++) begin
         if (req[i]) begin
            if (int'(rank) < EDGES) begin
               for (int k = 0; k < EDGES; k++) begin
                  if (int'(rank) == k) begin
                     edge_v[k] = 1'b1;
                     edge_a[k] = addr[i];
                     edge_d[k] = data[i];
                  end
               end
            end else begin
               reject[i] = 1'b1;
            end
            rank = rank + 1'b1;
         end
      end
   end

   // R3
   always_comb begin
      if (!$isunknown(req)) begin
         grant_count_chk: assert ($countones(edge_v) + $countones(reject) == $countones(req)
                                  && $countones(edge_v) <= EDGES)
            else $error("grant count mismatch");
      end
   end

endmodule

// File: rtl/dsplit_node.sv
module dsplit_node
   import dsplit_pkg::*;
#(
   parameter int unsigned DILATION = 2,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned STAGE    = 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [2*DILATION-1:0]               in_valid,
   input  logic [2*DILATION-1:0][ADDR_W-1:0]   in_addr,
   input  logic [2*DILATION-1:0][DATA_W-1:0]   in_data,
   output logic [DILATION-1:0]                 up_valid,
   output logic [DILATION-1:0][ADDR_W-1:0]     up_addr,
   output logic [DILATION-1:0][DATA_W-1:0]     up_data,
   output logic [DILATION-1:0]                 dn_valid,
   output logic [DILATION-1:0][ADDR_W-1:0]     dn_addr,
   output logic [DILATION-1:0][DATA_W-1:0]     dn_data,
   output logic [2*DILATION-1:0]               blocked
);

   localparam int unsigned PORTS = 2 * DILATION;

   if (DILATION < 1) begin : g_bad_dil
      $error("dsplit_node: DILATION must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dsplit_node: widths must be positive");
   end

   logic [NUM_SIDES-1:0][PORTS-1:0]                req;
   logic [NUM_SIDES-1:0][DILATION-1:0]             e_v;
   logic [NUM_SIDES-1:0][DILATION-1:0][ADDR_W-1:0] e_a;
   logic [NUM_SIDES-1:0][DILATION-1:0][DATA_W-1:0] e_d;
   logic [NUM_SIDES-1:0][PORTS-1:0]                rej;

   dsplit_steer #(
      .PORTS (PORTS),
      .ADDR_W(ADDR_W),
      .STAGE (STAGE)
   ) u_steer (
      .valid(in_valid),
      .addr (in_addr),
      .req  (req)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dsplit_alloc #(
         .PORTS (PORTS),
         .EDGES (DILATION),
         .ADDR_W(ADDR_W),
         .DATA_W(DATA_W)
      ) u_alloc (
         .req   (req[s]),
         .addr  (in_addr),
         .data  (in_data),
         .edge_v(e_v[s]),
         .edge_a(e_a[s]),
         .edge_d(e_d[s]),
         .reject(rej[s])
      );
   end

   logic primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_valid <= '0;
         up_addr  <= '0;
         up_data  <= '0;
         dn_valid <= '0;
         dn_addr  <= '0;
         dn_data  <= '0;
         blocked  <= '0;
         primed   <= 1'b0;
      end else begin
         up_valid <= e_v[SIDE_UP];
         up_addr  <= e_a[SIDE_UP];
         up_data  <= e_d[SIDE_UP];
         dn_valid <= e_v[SIDE_DN];
         dn_addr  <= e_a[SIDE_DN];
         dn_data  <= e_d[SIDE_DN];
         blocked  <= rej[SIDE_UP] | rej[SIDE_DN];
         primed   <= 1'b1;
      end
   end

   // R3
   conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> ($countones(up_valid) + $countones(dn_valid) + $countones(blocked)
                  == $countones($past(in_valid))))
      else $error("messages not conserved");

   // R3
   block_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|blocked) |-> ((&up_valid) || (&dn_valid)))
      else $error("drop while edges free");

   // R4
   block_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> ((blocked & ~$past(in_valid)) == '0))
      else $error("blocked on idle port");

   // R8
   contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((up_valid & (up_valid + 1'b1)) == '0) && ((dn_valid & (dn_valid + 1'b1)) == '0))
      else $error("edge gap");

endmodule

// File: tb/dsplit_node_test.sv
`timescale 1ns/1ps
module dsplit_node_test;

   localparam int D  = 2;
   localparam int P  = 2 * D;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int ST = 1;
   localparam int SEL = AW - 1 - ST;

   typedef struct packed {
      logic [D-1:0]          uv;
      logic [D-1:0][AW-1:0]  ua;
      logic [D-1:0][DW-1:0]  ud;
      logic [D-1:0]          dv;
      logic [D-1:0][AW-1:0]  da;
      logic [D-1:0][DW-1:0]  dd;
      logic [P-1:0]          blk;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [P-1:0]         in_valid = '0;
   logic [P-1:0][AW-1:0] in_addr  = '0;
   logic [P-1:0][DW-1:0] in_data  = '0;
   logic [D-1:0]         up_valid, dn_valid;
   logic [D-1:0][AW-1:0] up_addr, dn_addr;
   logic [D-1:0][DW-1:0] up_data, dn_data;
   logic [P-1:0]         blocked;

   int checks = 0;
   int fails  = 0;
   exp_t  exp_q[$];
   string tag_q[$];
   bit    done = 0;

   always #2.5 clk = ~clk;

   dsplit_node #(.DILATION(D), .ADDR_W(AW), .DATA_W(DW), .STAGE(ST)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
      .up_valid(up_valid), .up_addr(up_addr), .up_data(up_data),
      .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_data(dn_data),
      .blocked(blocked)
   );

   function automatic exp_t model(input logic [P-1:0] v,
                                  input logic [P-1:0][AW-1:0] a,
                                  input logic [P-1:0][DW-1:0] d);
      exp_t e;
      int nu, nd;
      e = '0; nu = 0; nd = 0;
      for (int i = 0; i < P; i++) begin
         if (v[i]) begin
            if (a[i][SEL] == 1'b0) begin
               if (nu < D) begin e.uv[nu] = 1'b1; e.ua[nu] = a[i]; e.ud[nu] = d[i]; end
               else e.blk[i] = 1'b1;
               nu++;
            end else begin
               if (nd < D) begin e.dv[nd] = 1'b1; e.da[nd] = a[i]; e.dd[nd] = d[i]; end
               else e.blk[i] = 1'b1;
               nd++;
            end
         end
      end
      return e;
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input string tag, input logic [P-1:0] v,
                        input logic [P-1:0][AW-1:0] a, input logic [P-1:0][DW-1:0] d);
      @(negedge clk);
      in_valid = v; in_addr = a; in_data = d;
      exp_q.push_back(model(v, a, d));
      tag_q.push_back(tag);
   endtask

   // monitor: results of inputs set at a negedge appear after the next posedge (R6)
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "up_valid", 64'(up_valid), 64'(e.uv));
            check(t, "dn_valid", 64'(dn_valid), 64'(e.dv));
            check(t, "blocked",  64'(blocked),  64'(e.blk));
            for (int k = 0; k < D; k++) begin
               if (e.uv[k]) check(t, "up_addr/data R6", {up_addr[k], up_data[k]}, {e.ua[k], e.ud[k]});
               if (e.dv[k]) check(t, "dn_addr/data R6", {dn_addr[k], dn_data[k]}, {e.da[k], e.dd[k]});
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R7: reset state, then just after release
      repeat (3) @(posedge clk);
      #1;
      check("R7", "valid in reset", 64'({up_valid, dn_valid, blocked}), 64'(0));
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R7", "valid after release", 64'({up_valid, dn_valid, blocked}), 64'(0));

      // R1: steering bit 1 selects side; other bits toggled
      drive("R1", 4'b0001, {3'd0, 3'd0, 3'd0, 3'b000}, {8'h0, 8'h0, 8'h0, 8'hA1});
      drive("R1", 4'b0001, {3'd0, 3'd0, 3'd0, 3'b010}, {8'h0, 8'h0, 8'h0, 8'hA2});
      drive("R1", 4'b0011, {3'd0, 3'd0, 3'b101, 3'b110}, {8'h0, 8'h0, 8'hB1, 8'hB2});
      // R2: ascending order on one side
      drive("R2", 4'b1010, {3'b001, 3'd0, 3'b100, 3'd0}, {8'hC3, 8'h0, 8'hC1, 8'h0});
      // R3: four up requests, two dropped
      drive("R3", 4'b1111, {3'b000, 3'b001, 3'b100, 3'b101}, {8'hD3, 8'hD2, 8'hD1, 8'hD0});
      // R3: four down requests
      drive("R3", 4'b1111, {3'b010, 3'b011, 3'b110, 3'b111}, {8'hE3, 8'hE2, 8'hE1, 8'hE0});
      // R4: invalid ports with down addresses take nothing
      drive("R4", 4'b0100, {3'b010, 3'b010, 3'b010, 3'b010}, {8'h11, 8'h22, 8'h33, 8'h44});
      drive("R4", 4'b0000, {3'b111, 3'b111, 3'b111, 3'b111}, {8'h55, 8'h66, 8'h77, 8'h88});
      // R5: one message only, other edges idle
      drive("R5", 4'b1000, {3'b011, 3'd0, 3'd0, 3'd0}, {8'h9A, 8'h0, 8'h0, 8'h0});
      // R9: up saturated by three, down gets one
      drive("R9", 4'b1111, {3'b000, 3'b110, 3'b001, 3'b100}, {8'hF3, 8'hF2, 8'hF1, 8'hF0});
      // R8 / R6: random back-to-back traffic
      for (int n = 0; n < 60; n++) begin
         logic [P-1:0]         v;
         logic [P-1:0][AW-1:0] a;
         logic [P-1:0][DW-1:0] d;
         v = P'($urandom);
         a = (P*AW)'($urandom);
         d = (P*DW)'($urandom);
         drive("R8", v, a, d);
      end
      drive("R6", 4'b0000, '0, '0);
      repeat (3) @(posedge clk);
      #1;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule